// File: doc/BRIEF.md
# Vsync-Latched Window Shadow Register Bank

This block holds the per-window configuration of a display overlay engine as two copies. Software writes land in a staging copy. The scanout logic reads an active copy. The active copy of a window takes on the staged values only on a vsync pulse. This lets a change that spans several registers, such as a new buffer address, geometry and enable, reach the pixel pipeline in one frame boundary rather than being seen half-written.

Each window has a protect bit, held in a shared protect register. While a window is protected, a vsync leaves its active copy untouched. Clearing the bit applies nothing by itself; the staged set moves across at the first vsync after that. Software normally protects every window, writes its update, and then unprotects them all.

Not every window has every register. Window 0 has no alpha or colour-key slot. Windows 3 and 4 have no size slot. These absent slots hold nothing and read as zero.

Top module: `shadow_bank`

## Requirements
- R1: After reset, every staging slot, every active slot and every protect bit is zero, and every `win_live` bit is 0.
- R2: A write to an implemented slot at address {window[5:3], slot[2:0]} updates that slot's staging value on the clock edge. A read of the same address returns the staging value combinationally. The slots are: 0 control, 1 buffer start, 2 buffer end, 3 top-left, 4 bottom-right, 5 size, 6 alpha, 7 colour key.
- R3: An active slot never changes in a cycle without `vsync`; writes alone leave `act_regs` unchanged.
- R4: On a cycle with `vsync` high, each unprotected window copies all its staging slots into its active slots, visible after that clock edge.
- R5: On a cycle with `vsync` high, each protected window keeps its active slots unchanged.
- R6: Clearing a protect bit changes no active slot until the next `vsync`.
- R7: Window 0 slots 6 and 7 are absent: writes to them are ignored, and both their reads and their active values are zero.
- R8: Slot 5 of windows 3 and 4 is absent: writes to it are ignored, and both its reads and its active value are zero.
- R9: `win_live[w]` is 1 exactly when bit 0 (window enable) and bit 1 (channel enable) of window w's active control slot are both 1. A window that is disabled in staging therefore stays live until the next unprotected `vsync`.
- R10: The protect register sits at window address NUM_WIN, slot 0. Bit w protects window w, and the register reads back in its low NUM_WIN bits. All other addresses outside the windows read zero.
- R11: When a write and `vsync` fall in the same cycle, the active copy takes the staging value from before that write. A protect write in a `vsync` cycle acts from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | WIN_AW+3 | Write address {window, slot} |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | WIN_AW+3 | Read address {window, slot} |
| rd_data | output | DATA_W | Staging value or protect register at rd_addr |
| vsync | input | 1 | Single-cycle frame-boundary pulse |
| act_regs | output | NUM_WIN*8*DATA_W | Active slots, window-major, slot s of window w at bits (w*8+s)*DATA_W |
| win_live | output | NUM_WIN | Per-window scanout enable from active control |

## Verification
The bench builds the bank with the default five windows and a 16-bit data width. At that size every address, including the absent slots and the unused addresses above the protect register, can be swept on each pass. All 32 protect masks are then stepped through. Each mask is driven through a full protect, vsync, unprotect, vsync sequence, so that every window is seen both held and released. Control patterns that cover all four enable combinations, together with a write that coincides with vsync, bring the liveness and same-cycle ordering rules within reach.

// File: rtl/shadow_bank_pkg.sv
// Shared slot map and slot presence for the shadow register bank.
// Assumes eight slots per window; presence depends only on window index.
package shadow_bank_pkg;
    localparam int SLOTS       = 8;
    localparam int SLOT_AW     = 3;
    localparam int SLOT_CTRL   = 0;
    localparam int SLOT_SIZE   = 5;
    localparam int SLOT_ALPHA  = 6;
    localparam int SLOT_KEY    = 7;
    localparam int CTRL_WEN    = 0;
    localparam int CTRL_CHEN   = 1;

    // True when window `win` implements slot `slot`.
    function automatic bit slot_present(input int win, input int slot);
        if (win == 0 && (slot == SLOT_ALPHA || slot == SLOT_KEY)) return 1'b0;
        if ((win == 3 || win == 4) && slot == SLOT_SIZE) return 1'b0;
        return 1'b1;
    endfunction
endpackage

// File: rtl/shadow_prot.sv
// Protect register: one bit per window, written from the register port.
// Assumes the caller decodes the protect address into prot_we.
module shadow_prot #(
    parameter int NUM_WIN = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prot_we,
    input  logic [NUM_WIN-1:0] prot_wdata,
    output logic [NUM_WIN-1:0] prot_q
);
    // Hold protect bits; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       prot_q <= '0;
        else if (prot_we) prot_q <= prot_wdata;
    end

    assert_prot_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prot_we |=> prot_q == $past(prot_wdata));
    assert_prot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_we |=> $stable(prot_q));
endmodule

// File: rtl/shadow_win.sv
// One window: staging and active copies of each implemented slot.
// Absent slots are constant zero. Active loads from staging on vsync when
// not protected; the copy uses staging as it stood before this edge.
module shadow_win
    import shadow_bank_pkg::*;
#(
    parameter int WIN_IDX = 0,
    parameter int DATA_W  = 32,
    localparam int WIN_W  = SLOTS * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_AW-1:0] wr_slot,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               vsync,
    input  logic               prot,
    output logic [WIN_W-1:0]   stg_flat,
    output logic [WIN_W-1:0]   act_flat
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (slot_present(WIN_IDX, s)) begin : g_impl
            logic [DATA_W-1:0] stg_q, act_q;
            // Staging copy: takes software writes to this slot.
            always_ff @(posedge clk) begin
                if (!rst_n)                                    stg_q <= '0;
                else if (wr_en && wr_slot == SLOT_AW'(s))      stg_q <= wr_data;
            end
            // Active copy: loads staging on an unprotected vsync.
            always_ff @(posedge clk) begin
                if (!rst_n)              act_q <= '0;
                else if (vsync && !prot) act_q <= stg_q;
            end
            assign stg_flat[s*DATA_W +: DATA_W] = stg_q;
            assign act_flat[s*DATA_W +: DATA_W] = act_q;
        end else begin : g_absent
            assign stg_flat[s*DATA_W +: DATA_W] = '0;
            assign act_flat[s*DATA_W +: DATA_W] = '0;
        end
    end

    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(act_flat));
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && !prot) |=> act_flat == $past(stg_flat));
    assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && prot) |=> $stable(act_flat));
endmodule

// File: rtl/shadow_bank.sv
// Top of the vsync-latched shadow register bank. Decodes {window, slot}
// addresses, hosts one shadow_win per window plus the protect register,
// muxes staging values to the read port and derives per-window liveness.
// Assumes vsync is a single-cycle pulse in the clk domain.
module shadow_bank
    import shadow_bank_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int DATA_W  = 32,
    localparam int WIN_AW = $clog2(NUM_WIN + 1),
    localparam int ADDR_W = WIN_AW + SLOT_AW,
    localparam int WIN_W  = SLOTS * DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     vsync,
    output logic [NUM_WIN*WIN_W-1:0] act_regs,
    output logic [NUM_WIN-1:0]       win_live
);
    logic [WIN_AW-1:0]              wr_win, rd_win;
    logic [SLOT_AW-1:0]             wr_slot, rd_slot;
    logic [NUM_WIN-1:0]             prot_q;
    logic                           prot_we;
    logic [NUM_WIN-1:0][WIN_W-1:0]  stg_all, act_all;

    assign {wr_win, wr_slot} = wr_addr;
    assign {rd_win, rd_slot} = rd_addr;
    assign prot_we = wr_en && wr_win == WIN_AW'(NUM_WIN) && wr_slot == '0;

    shadow_prot #(.NUM_WIN(NUM_WIN)) u_prot (
        .clk(clk), .rst_n(rst_n), .prot_we(prot_we),
        .prot_wdata(wr_data[NUM_WIN-1:0]), .prot_q(prot_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        shadow_win #(.WIN_IDX(w), .DATA_W(DATA_W)) u_win (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en && wr_win == WIN_AW'(w)),
            .wr_slot(wr_slot), .wr_data(wr_data),
            .vsync(vsync), .prot(prot_q[w]),
            .stg_flat(stg_all[w]), .act_flat(act_all[w])
        );
        assign win_live[w] = act_all[w][SLOT_CTRL*DATA_W + CTRL_WEN]
                           & act_all[w][SLOT_CTRL*DATA_W + CTRL_CHEN];

        assert_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $changed(win_live[w]) |-> $past(vsync) && !$past(prot_q[w]));
    end

    assign act_regs = act_all;

    // Read mux: staging value of the addressed slot, or protect bits.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (rd_win == WIN_AW'(w)) rd_data = stg_all[w][rd_slot*DATA_W +: DATA_W];
        end
        if (rd_win == WIN_AW'(NUM_WIN) && rd_slot == '0)
            rd_data = {{(DATA_W-NUM_WIN){1'b0}}, prot_q};
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> act_regs == '0 && prot_q == '0);
endmodule

// File: tb/tb_shadow_bank.sv
module tb_shadow_bank;
    localparam int NW = 5, DW = 16, AW = 6;
    logic clk = 0, rst_n = 0, wr_en = 0, vsync = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic [NW*8*DW-1:0] act_regs;
    logic [NW-1:0] win_live;
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [DW-1:0] m_stg [NW][8];
    logic [DW-1:0] m_act [NW][8];
    logic [NW-1:0] m_prot;

    shadow_bank #(.NUM_WIN(NW), .DATA_W(DW)) dut (.*);

    always #5 clk = ~clk;

    function automatic bit present(int w, int s);
        if (w == 0 && s >= 6) return 0;   // R7
        if (w >= 3 && s == 5) return 0;   // R8
        return 1;
    endfunction

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int w, int s, logic [DW-1:0] d, bit with_vs = 0);
        @(negedge clk);
        wr_en = 1; wr_addr = {w[2:0], s[2:0]}; wr_data = d; vsync = with_vs;
        @(negedge clk);
        wr_en = 0; vsync = 0;
        if (with_vs) for (int v = 0; v < NW; v++)
            if (!m_prot[v]) for (int k = 0; k < 8; k++) m_act[v][k] = m_stg[v][k];
        if (w < NW && present(w, s)) m_stg[w][s] = d;
        else if (w == NW && s == 0) m_prot = d[NW-1:0];
    endtask

    task automatic pulse();
        @(negedge clk); vsync = 1;
        @(negedge clk); vsync = 0;
        for (int v = 0; v < NW; v++)
            if (!m_prot[v]) for (int k = 0; k < 8; k++) m_act[v][k] = m_stg[v][k];
    endtask

    task automatic check_all(string tag);
        for (int w = 0; w < NW; w++) begin
            for (int s = 0; s < 8; s++) begin
                rd_addr = {w[2:0], s[2:0]}; #1;
                check(rd_data == m_stg[w][s], {tag, " read R2"}, rd_data, m_stg[w][s]);
                check(act_regs[(w*8+s)*DW +: DW] == m_act[w][s], tag,
                      act_regs[(w*8+s)*DW +: DW], m_act[w][s]);
            end
            check(win_live[w] == (m_act[w][0][0] & m_act[w][0][1]), "R9 live",
                  DW'(win_live[w]), DW'(m_act[w][0][0] & m_act[w][0][1]));
        end
        rd_addr = {3'(NW), 3'd0}; #1;
        check(rd_data == DW'(m_prot), "R10 prot read", rd_data, DW'(m_prot));
        for (int s = 1; s < 8; s++) begin
            rd_addr = {3'(NW), s[2:0]}; #1;
            check(rd_data == 0, "R10 unused", rd_data, 0);
        end
        for (int a = (NW+1)*8; a < 64; a++) begin
            rd_addr = AW'(a); #1;
            check(rd_data == 0, "R10 unused", rd_data, 0);
        end
    endtask

    function automatic logic [DW-1:0] pat(int r, int w, int s);
        return DW'(r * 37 + w * 8 + s + 1) ^ DW'(r << 9);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NW; w++) for (int s = 0; s < 8; s++) begin
            m_stg[w][s] = 0; m_act[w][s] = 0;
        end
        m_prot = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");
        // Fill all addresses, absent slots included (R7, R8); no vsync yet (R3).
        for (int w = 0; w < NW; w++) for (int s = 0; s < 8; s++) wr(w, s, pat(1, w, s));
        check_all("R3 no vsync");
        pulse();
        check_all("R4 load");
        // Every protect mask: protect, stage, vsync, unprotect, vsync.
        for (int m = 0; m < 32; m++) begin
            wr(NW, 0, DW'(m));
            for (int w = 0; w < NW; w++) for (int s = 0; s < 8; s++)
                wr(w, s, (s == 0) ? DW'((m + w) & 3) : pat(m + 2, w, s));
            check_all("R3 staged");
            pulse();
            check_all("R5 protect");
            wr(NW, 0, 0);
            check_all("R6 unprotect");
            pulse();
            check_all("R4 release");
        end
        // Write in the vsync cycle: active takes prior staging (R11).
        wr(2, 1, 16'hA5A5, 1);
        check_all("R11 write+vsync");
        wr(NW, 0, 5'b00100, 1);
        wr(2, 1, 16'h5A5A, 1);
        check_all("R11 prot+vsync");
        pulse();
        check_all("R11 held");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule